// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

This block controls one general-purpose I/O port of four or eight bits. A CPU configures it through a small register interface. For each bit the CPU sets a direction, an output data value, a drive mode and routing to the shared global buses. For each bit it also selects an interrupt condition. The block turns these settings into four pad-facing control vectors: output enable, output value, pull-up enable and pull-down enable. The pin levels pass through a two-flop synchronizer. The CPU then reads them back, the global input bus receives them, and the interrupt logic watches them for events.

Each bit can raise an interrupt on a rising edge or a falling edge. It can also raise one when the pin differs from the value the CPU last read from the data register. Per-bit status is sticky and is cleared by writing 1. The single interrupt output is the OR of the status bits whose interrupt type is not off.

After an external reset is released, one designated bit is driven strongly low for `HOLD_CYCLES` clock cycles. This models a hold-off of roughly 16 ms. During that window the CPU may still write that bit's data, direction, mode and interrupt settings. The written output takes effect only when the window ends. A power-on reset never starts the hold-off.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After power-on reset, every configuration register reads 0 and pad_oe, pad_pu, pad_pd and irq_o are all 0.
- R2: A read at address 0 returns the pin value delayed by two clock edges through the synchronizer. Addresses 1 to 8 read back direction, mode bit 0, mode bit 1, input routing, output routing, type bit 0, type bit 1 and status, in that order.
- R3: When a bit has direction 1 and mode 00 (strong), pad_oe is 1 and pad_o equals the bit's output value. When direction is 0, pad_oe is 0.
- R4: Mode 01 is resistive pull-up: an output 1 gives pu=1 with oe=0, and an output 0 gives oe=1 with o=0. Mode 10 is resistive pull-down: an output 0 gives pd=1 with oe=0, and an output 1 gives oe=1 with o=1. With direction 0, pu or pd follows the mode. The mode is {address 3 bit, address 2 bit}.
- R5: Mode 11 (high impedance) drives oe, pu and pd to 0 for that bit.
- R6: gbus_in_o equals the synchronized pin ANDed with the input-routing register. Where the output-routing bit is 1, the output value is taken from gbus_out_i instead of the data register.
- R7: Interrupt type 01 ({address 7 bit, address 6 bit}) sets the bit's status on a synchronized rising edge. The status is visible three edges after the pin changes.
- R8: Interrupt type 10 sets the status on a synchronized falling edge.
- R9: Interrupt type 11 sets the status while the synchronized pin differs from the snapshot. Every read at address 0 loads the snapshot.
- R10: Status bits are sticky and clear when 1 is written to them at address 8. irq_o is the OR of status bits whose type is not 00.
- R11: After xres_n is released, the hold bit (bit 0 by default) is driven strongly low for HOLD_CYCLES edges. External reset also clears all registers.
- R12: During the hold-off, writes to the hold bit's registers are accepted and take effect when the hold-off ends. Pin reads are unaffected. A power-on reset alone leaves no hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| xres_n | input | 1 | Synchronous external reset, active low; starts the hold-off |
| cpu_addr | input | 4 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe (loads the snapshot at address 0) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational, zero-extended |
| pin_i | input | WIDTH | Pin levels from the pads |
| pad_oe | output | WIDTH | Per-bit output enable |
| pad_o | output | WIDTH | Per-bit driven value |
| pad_pu | output | WIDTH | Per-bit pull-up enable |
| pad_pd | output | WIDTH | Per-bit pull-down enable |
| gbus_out_i | input | WIDTH | Global output bus |
| gbus_in_o | output | WIDTH | Global input bus |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The bench goes after the exact length of the hold-off. A counter that is off by one would release the pin one cycle early, or keep it low one cycle too long. It checks that data written during the hold-off survives, which a design that blocked those writes would lose. In change mode it checks that a read re-arms the comparison; a design that never loaded the snapshot would keep re-raising status after a clear. It also checks that turning a bit's type off masks its pending status from irq_o without erasing it. Random register traffic compares all four pad vectors against a drive-mode model, which catches a swapped pull polarity.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      DM_STRONG = 2'b00,
      DM_PULLUP = 2'b01,
      DM_PULLDN = 2'b10,
      DM_HIZ    = 2'b11
   } drive_mode_e;

   typedef enum logic [1:0] {
      IT_OFF    = 2'b00,
      IT_RISE   = 2'b01,
      IT_FALL   = 2'b10,
      IT_CHANGE = 2'b11
   } irq_type_e;

   localparam int ADDR_W = 4;
   localparam int BUS_W  = 8;

   localparam logic [ADDR_W-1:0] A_DATA = 4'd0;
   localparam logic [ADDR_W-1:0] A_DIR  = 4'd1;
   localparam logic [ADDR_W-1:0] A_DM0  = 4'd2;
   localparam logic [ADDR_W-1:0] A_DM1  = 4'd3;
   localparam logic [ADDR_W-1:0] A_GIN  = 4'd4;
   localparam logic [ADDR_W-1:0] A_GOUT = 4'd5;
   localparam logic [ADDR_W-1:0] A_IT0  = 4'd6;
   localparam logic [ADDR_W-1:0] A_IT1  = 4'd7;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q, stab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
      end else begin
         meta_q <= d_i;
         stab_q <= meta_q;
      end
   end

   assign q_o = stab_q;
endmodule

// File: rtl/gpio_holdoff.sv
module gpio_holdoff #(
   parameter int HOLD_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xres_n,
   output logic hold_o
);
   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!xres_n)    cnt_q <= LOAD;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign hold_o = (cnt_q != '0);

   // R11
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);
   // R11
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xres_n && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) || (cnt_q == LOAD));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
   import gpio_port_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst_n,
   input  logic [W-1:0] pin_s_i,
   input  logic [W-1:0] type0_i,
   input  logic [W-1:0] type1_i,
   input  logic         snap_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o,
   output logic         irq_o
);
   logic [W-1:0] prev_q, snap_q, stat_q, evt, en;

   always_comb begin
      for (int b = 0; b < W; b++) begin
         unique case (irq_type_e'({type1_i[b], type0_i[b]}))
            IT_RISE:   evt[b] = pin_s_i[b] & ~prev_q[b];
            IT_FALL:   evt[b] = ~pin_s_i[b] & prev_q[b];
            IT_CHANGE: evt[b] = pin_s_i[b] ^ snap_q[b];
            default:   evt[b] = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         snap_q <= '0;
         stat_q <= '0;
      end else if (!srst_n) begin
         prev_q <= '0;
         snap_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= pin_s_i;
         if (snap_i) snap_q <= pin_s_i;
         stat_q <= (stat_q & ~clr_i) | evt;
      end
   end

   assign en     = type0_i | type1_i;
   assign stat_o = stat_q;
   assign irq_o  = |(stat_q & en);

   // R10
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
      ((stat_q & ~clr_i) != '0) |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
   import gpio_port_pkg::*;
#(
   parameter int W        = 8,
   parameter int HOLD_BIT = 0
) (
   input  logic [W-1:0] dir_i,
   input  logic [W-1:0] dm0_i,
   input  logic [W-1:0] dm1_i,
   input  logic [W-1:0] val_i,
   input  logic         hold_i,
   output logic [W-1:0] oe_o,
   output logic [W-1:0] o_o,
   output logic [W-1:0] pu_o,
   output logic [W-1:0] pd_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic held;
      if (i == HOLD_BIT) begin : g_hold
         assign held = hold_i;
      end else begin : g_free
         assign held = 1'b0;
      end

      always_comb begin
         drive_mode_e m;
         m = drive_mode_e'({dm1_i[i], dm0_i[i]});
         {oe_o[i], o_o[i], pu_o[i], pd_o[i]} = 4'b0000;
         if (held) begin
            oe_o[i] = 1'b1;
         end else if (!dir_i[i]) begin
            pu_o[i] = (m == DM_PULLUP);
            pd_o[i] = (m == DM_PULLDN);
         end else begin
            unique case (m)
               DM_STRONG: begin oe_o[i] = 1'b1;     o_o[i] = val_i[i]; end
               DM_PULLUP: begin oe_o[i] = ~val_i[i]; pu_o[i] = val_i[i]; end
               DM_PULLDN: begin oe_o[i] = val_i[i]; o_o[i] = 1'b1; pd_o[i] = ~val_i[i]; end
               default:   ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int HOLD_CYCLES = 40,
   parameter int HOLD_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xres_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [BUS_W-1:0]  cpu_wdata,
   output logic [BUS_W-1:0]  cpu_rdata,
   input  logic [WIDTH-1:0]  pin_i,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_o,
   output logic [WIDTH-1:0]  pad_pu,
   output logic [WIDTH-1:0]  pad_pd,
   input  logic [WIDTH-1:0]  gbus_out_i,
   output logic [WIDTH-1:0]  gbus_in_o,
   output logic              irq_o
);
   if (!(WIDTH == 8 || WIDTH == 4)) begin : g_bad_width
      $error("WIDTH must be 4 or 8");
   end
   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 2");
   end
   if (HOLD_BIT < 0 || HOLD_BIT >= WIDTH) begin : g_bad_bit
      $error("HOLD_BIT must index a port bit");
   end

   localparam logic [WIDTH-1:0] HOLD_MASK = WIDTH'(1) << HOLD_BIT;

   logic [WIDTH-1:0] data_q, dir_q, dm0_q, dm1_q, gin_q, gout_q, it0_q, it1_q;
   logic [WIDTH-1:0] pin_s, stat, clr, val;
   logic             hold, snap;
   logic [WIDTH-1:0] wd;

   assign wd = cpu_wdata[WIDTH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {data_q, dir_q, dm0_q, dm1_q, gin_q, gout_q, it0_q, it1_q} <= '0;
      end else if (!xres_n) begin
         {data_q, dir_q, dm0_q, dm1_q, gin_q, gout_q, it0_q, it1_q} <= '0;
      end else if (cpu_wr) begin
         case (cpu_addr)
            A_DATA:  data_q <= wd;
            A_DIR:   dir_q  <= wd;
            A_DM0:   dm0_q  <= wd;
            A_DM1:   dm1_q  <= wd;
            A_GIN:   gin_q  <= wd;
            A_GOUT:  gout_q <= wd;
            A_IT0:   it0_q  <= wd;
            A_IT1:   it1_q  <= wd;
            default: ;
         endcase
      end
   end

   assign clr  = (cpu_wr && cpu_addr == A_STAT) ? wd : '0;
   assign snap = cpu_rd && (cpu_addr == A_DATA);

   always_comb begin
      cpu_rdata = '0;
      case (cpu_addr)
         A_DATA:  cpu_rdata[WIDTH-1:0] = pin_s;
         A_DIR:   cpu_rdata[WIDTH-1:0] = dir_q;
         A_DM0:   cpu_rdata[WIDTH-1:0] = dm0_q;
         A_DM1:   cpu_rdata[WIDTH-1:0] = dm1_q;
         A_GIN:   cpu_rdata[WIDTH-1:0] = gin_q;
         A_GOUT:  cpu_rdata[WIDTH-1:0] = gout_q;
         A_IT0:   cpu_rdata[WIDTH-1:0] = it0_q;
         A_IT1:   cpu_rdata[WIDTH-1:0] = it1_q;
         A_STAT:  cpu_rdata[WIDTH-1:0] = stat;
         default: ;
      endcase
   end

   gpio_sync #(.W(WIDTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s));

   gpio_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .xres_n(xres_n), .hold_o(hold));

   gpio_irq #(.W(WIDTH)) u_irq (
      .clk(clk), .rst_n(rst_n), .srst_n(xres_n), .pin_s_i(pin_s),
      .type0_i(it0_q), .type1_i(it1_q), .snap_i(snap), .clr_i(clr),
      .stat_o(stat), .irq_o(irq_o));

   assign val       = (gout_q & gbus_out_i) | (~gout_q & data_q);
   assign gbus_in_o = pin_s & gin_q;

   gpio_drive #(.W(WIDTH), .HOLD_BIT(HOLD_BIT)) u_drive (
      .dir_i(dir_q), .dm0_i(dm0_q), .dm1_i(dm1_q), .val_i(val), .hold_i(hold),
      .oe_o(pad_oe), .o_o(pad_o), .pu_o(pad_pu), .pd_o(pad_pd));

   // R11
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (pad_oe[HOLD_BIT] && !pad_o[HOLD_BIT] && !pad_pu[HOLD_BIT] && !pad_pd[HOLD_BIT]));
   // R4
   pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_pd) == '0) && ((pad_pu & pad_oe) == '0) && ((pad_pd & pad_oe) == '0));
   // R5
   hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dm0_q & dm1_q & ~(hold ? HOLD_MASK : '0)) & (pad_oe | pad_pu | pad_pd)) == '0);
endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
   localparam int W = 8;
   localparam int H = 20;

   logic clk = 0, rst_n = 0, xres_n = 1;
   logic [3:0] cpu_addr = '0;
   logic cpu_wr = 0, cpu_rd = 0;
   logic [7:0] cpu_wdata = '0, cpu_rdata;
   logic [W-1:0] pin_i = '0, pad_oe, pad_o, pad_pu, pad_pd, gbus_out_i = '0, gbus_in_o;
   logic irq_o;

   int checks = 0, errors = 0, since_rel = 0;
   logic [W-1:0] s_data, s_dir, s_dm0, s_dm1, s_gin, s_gout;

   always #2.5 clk = ~clk;

   always @(posedge clk) if (!xres_n) since_rel <= 0; else since_rel <= since_rel + 1;

   gpio_port_ctrl #(.WIDTH(W), .HOLD_CYCLES(H), .HOLD_BIT(0)) dut (
      .clk(clk), .rst_n(rst_n), .xres_n(xres_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_i(pin_i),
      .pad_oe(pad_oe), .pad_o(pad_o), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .gbus_out_i(gbus_out_i), .gbus_in_o(gbus_in_o), .irq_o(irq_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
      @(negedge clk); cpu_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); cpu_addr = a; cpu_rd = 1; #1 d = cpu_rdata;
      @(negedge clk); cpu_rd = 0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // {oe, o, pu, pd} for one bit
   function automatic logic [3:0] exp_bit(input logic d, input logic [1:0] m, input logic v);
      if (!d) return {2'b00, m == 2'b01, m == 2'b10};
      case (m)
         2'b00:   return {1'b1, v, 2'b00};
         2'b01:   return {~v, 1'b0, v, 1'b0};
         2'b10:   return {v, 1'b1, 1'b0, ~v};
         default: return 4'b0000;
      endcase
   endfunction

   task automatic check_pads(input string req);
      logic [W-1:0] eoe, eo, epu, epd;
      for (int i = 0; i < W; i++) begin
         logic v;
         v = s_gout[i] ? gbus_out_i[i] : s_data[i];
         {eoe[i], eo[i], epu[i], epd[i]} = exp_bit(s_dir[i], {s_dm1[i], s_dm0[i]}, v);
      end
      check(req, {pad_oe, pad_o, pad_pu, pad_pd}, {eoe, eo, epu, epd});
   endtask

   task automatic clear_shadow();
      {s_data, s_dir, s_dm0, s_dm1, s_gin, s_gout} = '0;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      void'($urandom(32'h1234_5678));
      clear_shadow();
      tick(3);
      @(negedge clk); rst_n = 1;
      tick(2);
      // R1 reset state
      check("R1 pads", {pad_oe, pad_pu, pad_pd, 7'b0, irq_o}, '0);
      rd(4'd1, r); check("R1 dir reg", r, 8'h00);
      rd(4'd8, r); check("R1 stat reg", r, 8'h00);

      // R12 power-on reset gives no hold-off on bit 0
      wr(4'd1, 8'h01); wr(4'd0, 8'h01);
      s_dir = 8'h01; s_data = 8'h01;
      check("R12 no holdoff after POR", {pad_oe[0], pad_o[0]}, 2'b11);

      // R2..R6 random traffic
      for (int it = 0; it < 300; it++) begin
         logic [3:0] a;
         logic [7:0] d;
         a = 4'($urandom_range(0, 5));
         d = 8'($urandom);
         @(negedge clk);
         pin_i = W'($urandom);
         gbus_out_i = W'($urandom);
         cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
         @(negedge clk); cpu_wr = 0;
         case (a)
            4'd0: s_data = d; 4'd1: s_dir = d; 4'd2: s_dm0 = d;
            4'd3: s_dm1 = d;  4'd4: s_gin = d; default: s_gout = d;
         endcase
         tick(2);
         check_pads("R3 R4 R5 R6 pad model");
         check("R6 gbus_in", gbus_in_o, pin_i & s_gin);
         check("R10 irq off with types 00", irq_o, 1'b0);
         rd(4'd0, r); check("R2 pin read", r, pin_i);
         if (it % 50 == 0) begin
            rd(a, r);
            check("R2 reg readback", r, (a == 0) ? pin_i : d);
         end
      end

      // interrupts: stable pins, snapshot, clear
      @(negedge clk); pin_i = 8'h02;
      tick(4);
      rd(4'd0, r);
      wr(4'd6, 8'h05);            // bit0 rise (01), bit2 change (11)
      wr(4'd7, 8'h06);            // bit1 fall (10), bit2 change
      wr(4'd8, 8'hFF);
      tick(1);
      rd(4'd8, r); check("R10 stat clear", r, 8'h00);
      check("R10 irq idle", irq_o, 1'b0);

      @(negedge clk); pin_i = 8'h03;   // rise bit0
      tick(3);
      rd(4'd8, r); check("R7 rising sets bit0", r, 8'h01);
      check("R10 irq on", irq_o, 1'b1);
      wr(4'd8, 8'h01);
      rd(4'd8, r); check("R10 w1c", r, 8'h00);
      check("R10 irq off after clear", irq_o, 1'b0);

      @(negedge clk); pin_i = 8'h01;   // fall bit1
      tick(3);
      rd(4'd8, r); check("R8 falling sets bit1", r, 8'h02);
      wr(4'd8, 8'h02);

      @(negedge clk); pin_i = 8'h05;   // bit2 rises: change vs snapshot 0
      tick(3);
      rd(4'd8, r); check("R9 change sets bit2", r, 8'h04);
      wr(4'd8, 8'h04);
      tick(1);
      rd(4'd8, r); check("R9 change persists before read", r, 8'h04);
      rd(4'd0, r);                      // snapshot reload
      wr(4'd8, 8'h04);
      tick(2);
      rd(4'd8, r); check("R9 read re-arms", r, 8'h00);

      // R10 masking: pending status hidden when type turned off
      @(negedge clk); pin_i = 8'h04;
      tick(3);
      @(negedge clk); pin_i = 8'h05;
      tick(3);
      wr(4'd6, 8'h04);                  // bit0 type 00
      rd(4'd8, r); check("R10 status kept", r[0], 1'b1);
      check("R10 irq masked", irq_o, 1'b0);

      // R11 / R12 hold-off
      @(negedge clk); xres_n = 0; pin_i = 8'h00;
      tick(2);
      @(negedge clk); xres_n = 1;
      clear_shadow();
      rd(4'd1, r); check("R11 regs cleared by xres", r, 8'h00);
      wr(4'd1, 8'h01); wr(4'd0, 8'h01);
      s_dir = 8'h01; s_data = 8'h01;
      @(negedge clk); pin_i = 8'h80;
      tick(3);
      rd(4'd0, r); check("R12 input during hold", r, 8'h80);
      while (since_rel < H - 1) @(negedge clk);
      check("R11 held low at last cycle", {pad_oe[0], pad_o[0]}, 2'b10);
      tick(1);
      check("R12 written value after hold", {pad_oe[0], pad_o[0]}, 2'b11);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule